// File: doc/BRIEF.md
# Digital Lock Detect Filter with Hysteresis

This block tells a phase-locked loop controller whether the loop has settled. Every comparison cycle it measures, in ticks of a fast sample clock, the gap between the rising edge of the reference-divider pulse and the rising edge of the feedback-divider pulse. Either edge may arrive first. The gap is then judged against an acceptance window, and the result drives one lock flag.

The window has hysteresis. While the loop is unlocked, a tight window applies, and the flag rises only after an unbroken run of good cycles. Once the flag is up, a window twice as wide applies, and one bad cycle drops the flag. A comparison cycle whose partner edge never arrives counts as bad. A power-down input forces the flag low and discards any partial progress. With the default sample clock of 200 MHz (5 ns per tick), the windows are 3 and 6 ticks, roughly 15 ns and 30 ns.

Top module: `lock_detect_filter`

## Requirements
- R1: While rst_n is low, and in the first cycle after it is released, locked is 0.
- R2: The phase error of a cycle is the number of sample-clock ticks between the two rising edges, in either order. Edges sampled in the same cycle give an error of 0. The count saturates at 2^ERR_W-1.
- R3: While unlocked, locked goes to 1 two clock cycles after the partner edge of the GOOD_CYCLES-th consecutive cycle whose error is at most NARROW_TICKS. Fewer such cycles leave it at 0.
- R4: While unlocked, a cycle whose error exceeds NARROW_TICKS restarts the run of good cycles from zero.
- R5: While locked, a cycle whose error is at most WIDE_TICKS keeps locked at 1. This includes errors above NARROW_TICKS.
- R6: While locked, a single cycle whose error exceeds WIDE_TICKS clears locked two clock cycles after its partner edge.
- R7: If the partner edge has not arrived MISS_TICKS ticks after the first edge, the cycle counts as failed. A failed cycle clears locked, or restarts the run of good cycles.
- R8: While pwr_down is 1, locked is 0 from the next clock on, and cycles seen in that time do not count. After release, a full run of GOOD_CYCLES good cycles is needed again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast sample clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_down | input | 1 | Holds the flag low and halts measurement |
| ref_pulse | input | 1 | Reference-divider output, synchronous to clk |
| fb_pulse | input | 1 | Feedback-divider output, synchronous to clk |
| locked | output | 1 | Lock-detect flag |

## Verification
The bench builds the block with NARROW_TICKS=3, WIDE_TICKS=6, GOOD_CYCLES=5, MISS_TICKS=40 and ERR_W=8.

The small window widths let short pulse offsets land on both sides of each threshold: 3 against 4 ticks, and 6 against 7 ticks. The offsets are applied with both signs, so either edge leads.

The short timeout brings the missing-edge path within a few dozen cycles, both while a run of good cycles is building and while locked. The run length of five allows the bench to break a run at its last step and to confirm that the flag rises on exactly the fifth good cycle.

// File: rtl/lkd_pkg.sv
package lkd_pkg;
  typedef enum logic {
    MS_IDLE = 1'b0,
    MS_WAIT = 1'b1
  } meas_state_t;
endpackage

// File: rtl/lkd_edge_meas.sv
module lkd_edge_meas
  import lkd_pkg::*;
#(
  parameter int ERR_W      = 8,
  parameter int MISS_TICKS = 200
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             ref_pulse,
  input  logic             fb_pulse,
  output logic             meas_valid,
  output logic [ERR_W-1:0] meas_err,
  output logic             meas_miss
);
  localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};
  localparam logic [ERR_W-1:0] MISS_L  = ERR_W'(MISS_TICKS);

  meas_state_t      state_q, state_d;
  logic [ERR_W-1:0] cnt_q, cnt_d;
  logic             first_ref_q, first_ref_d;
  logic             ref_q, fb_q;
  logic             valid_d, miss_d;
  logic [ERR_W-1:0] err_d;
  logic             ref_rise, fb_rise, partner;

  assign ref_rise = ref_pulse & ~ref_q;
  assign fb_rise  = fb_pulse & ~fb_q;
  assign partner  = first_ref_q ? fb_rise : ref_rise;

  always_comb begin
    state_d     = state_q;
    cnt_d       = cnt_q;
    first_ref_d = first_ref_q;
    valid_d     = 1'b0;
    miss_d      = 1'b0;
    err_d       = meas_err;
    if (pwr_down) begin
      state_d = MS_IDLE;
      cnt_d   = '0;
    end else begin
      case (state_q)
        MS_IDLE: begin
          if (ref_rise && fb_rise) begin
            valid_d = 1'b1;
            err_d   = '0;
          end else if (ref_rise || fb_rise) begin
            state_d     = MS_WAIT;
            cnt_d       = ERR_W'(1);
            first_ref_d = ref_rise;
          end
        end
        MS_WAIT: begin
          if (partner) begin
            valid_d = 1'b1;
            err_d   = cnt_q;
            state_d = MS_IDLE;
          end else if (cnt_q >= MISS_L) begin
            valid_d = 1'b1;
            miss_d  = 1'b1;
            err_d   = ERR_MAX;
            state_d = MS_IDLE;
          end else if (cnt_q != ERR_MAX) begin
            cnt_d = cnt_q + ERR_W'(1);
          end
        end
        default: state_d = MS_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= MS_IDLE;
      cnt_q       <= '0;
      first_ref_q <= 1'b0;
      ref_q       <= 1'b0;
      fb_q        <= 1'b0;
      meas_valid  <= 1'b0;
      meas_miss   <= 1'b0;
      meas_err    <= '0;
    end else begin
      state_q     <= state_d;
      cnt_q       <= cnt_d;
      first_ref_q <= first_ref_d;
      ref_q       <= ref_pulse;
      fb_q        <= fb_pulse;
      meas_valid  <= valid_d;
      meas_miss   <= miss_d;
      meas_err    <= err_d;
    end
  end

  // R2
  err_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (meas_valid && !meas_miss) |-> (meas_err <= MISS_L));

  // R7
  meas_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == MS_WAIT && cnt_q >= MISS_L && !partner && !pwr_down)
      |=> (meas_valid && meas_miss));
endmodule

// File: rtl/lkd_qualifier.sv
module lkd_qualifier #(
  parameter int ERR_W        = 8,
  parameter int NARROW_TICKS = 3,
  parameter int WIDE_TICKS   = 6,
  parameter int GOOD_CYCLES  = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pwr_down,
  input  logic             meas_valid,
  input  logic [ERR_W-1:0] meas_err,
  input  logic             meas_miss,
  output logic             locked
);
  localparam int               GOOD_W   = $clog2(GOOD_CYCLES + 1);
  localparam logic [ERR_W-1:0] NARROW_L = ERR_W'(NARROW_TICKS);
  localparam logic [ERR_W-1:0] WIDE_L   = ERR_W'(WIDE_TICKS);
  localparam logic [GOOD_W-1:0] LAST_L  = GOOD_W'(GOOD_CYCLES - 1);

  logic [GOOD_W-1:0] streak_q, streak_d;
  logic              locked_d;
  logic              good_narrow, bad_wide;

  assign good_narrow = !meas_miss && (meas_err <= NARROW_L);
  assign bad_wide    = meas_miss || (meas_err > WIDE_L);

  always_comb begin
    streak_d = streak_q;
    locked_d = locked;
    if (pwr_down) begin
      streak_d = '0;
      locked_d = 1'b0;
    end else if (meas_valid) begin
      if (locked) begin
        streak_d = '0;
        if (bad_wide) locked_d = 1'b0;
      end else if (good_narrow) begin
        if (streak_q >= LAST_L) begin
          locked_d = 1'b1;
          streak_d = '0;
        end else begin
          streak_d = streak_q + GOOD_W'(1);
        end
      end else begin
        streak_d = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      streak_q <= '0;
      locked   <= 1'b0;
    end else begin
      streak_q <= streak_d;
      locked   <= locked_d;
    end
  end

  // R8
  pd_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_down |=> !locked);

  // R3
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(meas_valid && !meas_miss && meas_err <= NARROW_L));

  // R4
  streak_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!locked && meas_valid && !good_narrow) |=> (streak_q == '0 && !locked));

  // R5
  lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && !pwr_down && !(meas_valid && bad_wide)) |=> locked);

  // R6
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (locked && meas_valid && bad_wide) |=> !locked);
endmodule

// File: rtl/lock_detect_filter.sv
module lock_detect_filter #(
  parameter int ERR_W        = 8,
  parameter int NARROW_TICKS = 3,
  parameter int WIDE_TICKS   = 2 * NARROW_TICKS,
  parameter int GOOD_CYCLES  = 5,
  parameter int MISS_TICKS   = 200
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwr_down,
  input  logic ref_pulse,
  input  logic fb_pulse,
  output logic locked
);
  logic             meas_valid;
  logic [ERR_W-1:0] meas_err;
  logic             meas_miss;

  lkd_edge_meas #(
    .ERR_W      (ERR_W),
    .MISS_TICKS (MISS_TICKS)
  ) i_meas (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .ref_pulse  (ref_pulse),
    .fb_pulse   (fb_pulse),
    .meas_valid (meas_valid),
    .meas_err   (meas_err),
    .meas_miss  (meas_miss)
  );

  lkd_qualifier #(
    .ERR_W        (ERR_W),
    .NARROW_TICKS (NARROW_TICKS),
    .WIDE_TICKS   (WIDE_TICKS),
    .GOOD_CYCLES  (GOOD_CYCLES)
  ) i_qual (
    .clk        (clk),
    .rst_n      (rst_n),
    .pwr_down   (pwr_down),
    .meas_valid (meas_valid),
    .meas_err   (meas_err),
    .meas_miss  (meas_miss),
    .locked     (locked)
  );

  // R1
  reset_low_chk: assert property (@(posedge clk)
    !rst_n |=> !locked);
endmodule

// File: tb/test_lock_detect_filter.sv
module test_lock_detect_filter;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_down = 1'b0;
  logic ref_pulse = 1'b0;
  logic fb_pulse = 1'b0;
  logic locked;

  int n_checks = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  lock_detect_filter #(
    .ERR_W(8), .NARROW_TICKS(3), .WIDE_TICKS(6),
    .GOOD_CYCLES(5), .MISS_TICKS(40)
  ) i_lock_detect_filter (
    .clk(clk), .rst_n(rst_n), .pwr_down(pwr_down),
    .ref_pulse(ref_pulse), .fb_pulse(fb_pulse), .locked(locked)
  );

  localparam int NV = 20;
  // offset of feedback edge relative to reference edge, in ticks
  localparam int DELTA [NV] = '{1, -2, 3, 0, -3, 5, -6, 4, -7, 2,
                                -1, 2, 1, 4, 1, 1, 1, 1, 1, 7};
  localparam bit EXPV [NV]  = '{0, 0, 0, 0, 1, 1, 1, 1, 0, 0,
                                0, 0, 0, 0, 0, 0, 0, 0, 1, 0};
  // R3 rows 0-4 (R2 at row 3, zero gap), R5 rows 5-7, R6 rows 8 and 19,
  // R4 rows 9-18 (row 13 breaks the run at its fifth step)
  localparam int TAG [NV]   = '{3, 3, 3, 2, 3, 5, 5, 5, 6, 4,
                                4, 4, 4, 4, 4, 4, 4, 4, 4, 6};

  task automatic check(input bit act, input bit exp, input string req);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: locked=%0b expected %0b", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic comp_cycle(input int d);
    int ad = (d < 0) ? -d : d;
    int ri = (d < 0) ? ad : 0;
    int fi = (d < 0) ? 0 : ad;
    for (int i = 0; i <= ad; i++) begin
      @(negedge clk);
      ref_pulse = (i == ri);
      fb_pulse  = (i == fi);
    end
    @(negedge clk);
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
    wait_cyc(6);
  endtask

  task automatic lone_edge(input bit is_ref);
    @(negedge clk);
    ref_pulse = is_ref;
    fb_pulse  = !is_ref;
    @(negedge clk);
    ref_pulse = 1'b0;
    fb_pulse  = 1'b0;
    wait_cyc(50);
  endtask

  initial begin
    for (int c = 0; c < 150000; c++) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: locked=%0b expected finish", locked);
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    wait_cyc(3);
    check(locked, 1'b0, "R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(locked, 1'b0, "R1 after release");

    for (int v = 0; v < NV; v++) begin
      comp_cycle(DELTA[v]);
      check(locked, EXPV[v], $sformatf("R%0d vector %0d", TAG[v], v));
    end

    // R7: lone reference edge while locked
    for (int k = 0; k < 5; k++) comp_cycle(-1);
    check(locked, 1'b1, "R3 relock");
    lone_edge(1'b1);
    check(locked, 1'b0, "R7 missing feedback edge clears lock");

    // R7: lone feedback edge inside a run
    for (int k = 0; k < 4; k++) comp_cycle(2);
    lone_edge(1'b0);
    comp_cycle(2);
    check(locked, 1'b0, "R7 missing reference edge restarts run");
    for (int k = 0; k < 4; k++) comp_cycle(2);
    check(locked, 1'b1, "R7 full run after miss");

    // R8: power-down forces low and discards cycles
    @(negedge clk);
    pwr_down = 1'b1;
    @(negedge clk);
    check(locked, 1'b0, "R8 power-down clears flag");
    for (int k = 0; k < 5; k++) comp_cycle(0);
    check(locked, 1'b0, "R8 cycles ignored in power-down");
    pwr_down = 1'b0;
    for (int k = 0; k < 4; k++) comp_cycle(1);
    check(locked, 1'b0, "R8 partial run after release");
    comp_cycle(1);
    check(locked, 1'b1, "R8 full run after release");

    // R1: reset mid-run
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(locked, 1'b0, "R1 reset while locked");
    rst_n = 1'b1;

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule